// File: doc/BRIEF.md
# Sticky Event Status with Interrupt Masking

This block gathers thirty-two single-cycle event strobes into a status register whose bits hold once set and are wiped by a read of that register. A mask register of the same width gates the stored bits onto one interrupt line. A set mask bit blocks its status bit. The mask powers up with every bit set except the pass-through position. A host reaches both registers through a small read/write port. A select input chooses the register. Read data comes back one cycle after the read strobe.

Bit 23 does not behave like the other bits. It reflects a level input from a management-interface interrupt source. That level is never stored, a read does not clear it, and the mask cannot hide it from the interrupt line. It clears only when the source drops it. A second output, the fatal summary, is high while any stored bit of the fatal group (bit set 0xFC7C0000) is set, whatever the mask holds. The non-fatal group, 0x0002FEFC, reaches the interrupt only through the mask.

Top module: `irq_status_ctrl`

## Requirements
- R1: While reset is low and in the cycle after it, every stored status bit is 0, the mask is 0xFF7FFFFF, and the interrupt and fatal outputs are low when the level input is low.
- R2: An event strobe on bit k (k not 23) sets stored status bit k at the next clock edge, and the bit stays set until a status read.
- R3: A read with select 0 (status) returns, one cycle after the strobe, the stored bits as they were before that edge, with bit 23 equal to the level input at the strobe.
- R4: A status read clears every stored status bit at the same edge that captures the read data.
- R5: An event that arrives in the same cycle as a status read is left set after the read and is absent from that read's data.
- R6: A write with select 1 (mask) loads all 32 bits of write data into the mask, and a read with select 1 returns the mask without changing the status.
- R7: The interrupt output is high exactly when some stored status bit other than 23 is set with its mask bit 0, or the level input is high.
- R8: Bit 23 follows the level input. An event strobe on bit 23 is ignored, a status read does not clear it, and mask bit 23 cannot block it from the interrupt.
- R9: The fatal output is high while any stored bit in the set 0xFC7C0000 is set, regardless of the mask.
- R10: A write with select 0 has no effect on the status bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| evt_i | input | 32 | Single-cycle event strobes, one per status bit (bit 23 ignored) |
| mgmt_lvl_i | input | 1 | Level interrupt from the management interface, shown as bit 23 |
| rd_en_i | input | 1 | Register read strobe |
| wr_en_i | input | 1 | Register write strobe |
| sel_i | input | 1 | Register select: 0 status, 1 mask |
| wr_data_i | input | 32 | Write data |
| rd_data_o | output | 32 | Read data, valid the cycle after a read strobe |
| irq_o | output | 1 | Masked interrupt request |
| fatal_o | output | 1 | Fatal-error summary, unmasked |

## Verification
The hardest case to create from the ports is an event that lands on the exact edge where a status read clears the register. The read must return the old contents and still leave the new bit standing. The bench raises a strobe and the read strobe on the same falling edge. It then issues a second read to show that the new bit survived. A second hard case is the pass-through bit. With the mask fully set and a status read in between, the level input must still drive the interrupt line.

// File: rtl/irq_sts_pkg.sv
// Shared definitions for the sticky status / mask block.
// Assumes a single clock domain and that sel values are the only register codes.
package irq_sts_pkg;
    typedef enum logic {
        SEL_STATUS = 1'b0,
        SEL_MASK   = 1'b1
    } reg_sel_e;
endpackage

// File: rtl/irq_sts_store.sv
// Sticky status storage: each bit is set by its event strobe and held until
// a clear pulse. An event in the clear cycle wins over the clear.
// Assumes the caller has already removed any pass-through bit from evt_i.
module irq_sts_store #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] evt_i,
    input  logic             clr_i,
    output logic [WIDTH-1:0] stat_q
);
    // Hold-or-set per bit, with clear-on-read taking effect before new events.
    always_ff @(posedge clk) begin
        if (!rst_n) stat_q <= '0;
        else        stat_q <= (clr_i ? '0 : stat_q) | evt_i;
    end
endmodule

// File: rtl/irq_sts_mask.sv
// Mask register: full-width load on write, reset to a parameter value.
// Assumes writes are already qualified by the register select.
module irq_sts_mask #(
    parameter int               WIDTH      = 32,
    parameter logic [WIDTH-1:0] MASK_RESET = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we_i,
    input  logic [WIDTH-1:0] wdata_i,
    output logic [WIDTH-1:0] mask_q
);
    // Load the whole mask on a qualified write.
    always_ff @(posedge clk) begin
        if (!rst_n)    mask_q <= MASK_RESET;
        else if (we_i) mask_q <= wdata_i;
    end
endmodule

// File: rtl/irq_sts_merge.sv
// Combines stored status, mask and the level bit into the interrupt and
// fatal outputs, and registers read data.
// Assumes stat_i holds 0 at PASS_BIT (the level is taken from lvl_i).
module irq_sts_merge #(
    parameter int               WIDTH     = 32,
    parameter int               PASS_BIT  = 23,
    parameter logic [WIDTH-1:0] FATAL_SET = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] stat_i,
    input  logic [WIDTH-1:0] mask_i,
    input  logic             lvl_i,
    input  logic             rd_i,
    input  logic             sel_i,
    output logic [WIDTH-1:0] rd_data_o,
    output logic             irq_o,
    output logic             fatal_o
);
    logic [WIDTH-1:0] live_bits;
    logic [WIDTH-1:0] fire;

    // Per-bit interrupt contribution; the pass-through position ignores the mask.
    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        if (b == PASS_BIT) begin : g_pass
            assign live_bits[b] = lvl_i;
            assign fire[b]      = lvl_i;
        end else begin : g_mask
            assign live_bits[b] = stat_i[b];
            assign fire[b]      = stat_i[b] & ~mask_i[b];
        end
    end

    // Reduce the enabled bits to one request line.
    assign irq_o   = |fire;
    // Fatal summary looks at stored bits only, not at the mask.
    assign fatal_o = |(stat_i & FATAL_SET);

    // Capture the addressed register on a read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)    rd_data_o <= '0;
        else if (rd_i) rd_data_o <= sel_i ? mask_i : live_bits;
    end
endmodule

// File: rtl/irq_status_ctrl.sv
// Top: sticky clear-on-read event status with a mask-gated interrupt, an
// unmaskable pass-through level bit and an unmasked fatal summary.
// Assumes single-cycle strobes on evt_i and a single clock domain.
module irq_status_ctrl #(
    parameter int               WIDTH      = 32,
    parameter int               PASS_BIT   = 23,
    parameter logic [WIDTH-1:0] MASK_RESET = 32'hFF7F_FFFF,
    parameter logic [WIDTH-1:0] FATAL_SET  = 32'hFC7C_0000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] evt_i,
    input  logic             mgmt_lvl_i,
    input  logic             rd_en_i,
    input  logic             wr_en_i,
    input  logic             sel_i,
    input  logic [WIDTH-1:0] wr_data_i,
    output logic [WIDTH-1:0] rd_data_o,
    output logic             irq_o,
    output logic             fatal_o
);
    import irq_sts_pkg::*;

    localparam logic [WIDTH-1:0] PASS_ONE = {{(WIDTH-1){1'b0}}, 1'b1} << PASS_BIT;

    logic [WIDTH-1:0] stat_q;
    logic [WIDTH-1:0] mask_q;
    logic             stat_clr;
    logic             mask_we;

    // Decode the register port into a status clear and a mask load.
    assign stat_clr = rd_en_i && (reg_sel_e'(sel_i) == SEL_STATUS);
    assign mask_we  = wr_en_i && (reg_sel_e'(sel_i) == SEL_MASK);

    irq_sts_store #(.WIDTH(WIDTH)) u_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .evt_i  (evt_i & ~PASS_ONE),
        .clr_i  (stat_clr),
        .stat_q (stat_q)
    );

    irq_sts_mask #(.WIDTH(WIDTH), .MASK_RESET(MASK_RESET)) u_mask (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (mask_we),
        .wdata_i (wr_data_i),
        .mask_q  (mask_q)
    );

    irq_sts_merge #(.WIDTH(WIDTH), .PASS_BIT(PASS_BIT), .FATAL_SET(FATAL_SET)) u_merge (
        .clk       (clk),
        .rst_n     (rst_n),
        .stat_i    (stat_q),
        .mask_i    (mask_q),
        .lvl_i     (mgmt_lvl_i),
        .rd_i      (rd_en_i),
        .sel_i     (sel_i),
        .rd_data_o (rd_data_o),
        .irq_o     (irq_o),
        .fatal_o   (fatal_o)
    );
endmodule

// File: rtl/irq_status_chk.sv
// Checker for irq_status_ctrl, attached by bind. Observes ports and the
// stored status and mask of the top.
module irq_status_chk #(
    parameter int               WIDTH      = 32,
    parameter int               PASS_BIT   = 23,
    parameter logic [WIDTH-1:0] MASK_RESET = 32'hFF7F_FFFF,
    parameter logic [WIDTH-1:0] FATAL_SET  = 32'hFC7C_0000
) (
    input logic             clk,
    input logic             rst_n,
    input logic [WIDTH-1:0] evt_i,
    input logic             mgmt_lvl_i,
    input logic             rd_en_i,
    input logic             wr_en_i,
    input logic             sel_i,
    input logic             irq_o,
    input logic             fatal_o,
    input logic [WIDTH-1:0] stat_q,
    input logic [WIDTH-1:0] mask_q
);
    localparam logic [WIDTH-1:0] PASS_ONE = {{(WIDTH-1){1'b0}}, 1'b1} << PASS_BIT;

    AST_RESET_STATE: assert property (@(posedge clk) !rst_n |=> (mask_q == MASK_RESET && stat_q == '0)); // R1
    AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_en_i && !sel_i) |=> ((stat_q & $past(stat_q)) == $past(stat_q))); // R2
    AST_READ_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en_i && !sel_i) |=> (stat_q == ($past(evt_i) & ~PASS_ONE))); // R4
    AST_IDLE_NO_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        (!mgmt_lvl_i && stat_q == '0) |-> !irq_o); // R7
    AST_LEVEL_UNMASKED: assert property (@(posedge clk) disable iff (!rst_n)
        mgmt_lvl_i |-> irq_o); // R8
    AST_FATAL_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fatal_o) |-> $past(|(evt_i & FATAL_SET))); // R9
    AST_STATUS_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && !sel_i && !rd_en_i && evt_i == '0) |=> $stable(stat_q)); // R10
endmodule

bind irq_status_ctrl irq_status_chk #(
    .WIDTH(WIDTH), .PASS_BIT(PASS_BIT), .MASK_RESET(MASK_RESET), .FATAL_SET(FATAL_SET)
) u_chk (
    .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .mgmt_lvl_i(mgmt_lvl_i),
    .rd_en_i(rd_en_i), .wr_en_i(wr_en_i), .sel_i(sel_i),
    .irq_o(irq_o), .fatal_o(fatal_o), .stat_q(stat_q), .mask_q(mask_q)
);

// File: tb/sim_irq_status_ctrl.sv
module sim_irq_status_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] evt = '0;
    logic        lvl = 1'b0;
    logic        rd_en = 1'b0;
    logic        wr_en = 1'b0;
    logic        sel = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;
    logic        fatal;
    int          n_chk = 0;
    int          n_bad = 0;

    always #10 clk = ~clk;

    irq_status_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .evt_i(evt), .mgmt_lvl_i(lvl),
        .rd_en_i(rd_en), .wr_en_i(wr_en), .sel_i(sel), .wr_data_i(wdata),
        .rd_data_o(rdata), .irq_o(irq), .fatal_o(fatal)
    );

    // Vector: {mask, events, expected irq, expected fatal}
    localparam logic [65:0] VEC [9] = '{
        {32'hFF7F_FFFF, 32'h0000_0001, 1'b0, 1'b0},
        {32'hFFFF_FFFE, 32'h0000_0001, 1'b1, 1'b0},
        {32'hFFFF_FFFF, 32'h0004_0000, 1'b0, 1'b1},
        {32'h0000_0000, 32'h0002_0000, 1'b1, 1'b0},
        {32'hFF7F_FFFF, 32'h0080_0000, 1'b0, 1'b0},
        {32'h7FFF_FFFF, 32'h8000_0000, 1'b1, 1'b1},
        {32'h0000_FFFF, 32'h0000_FFFF, 1'b0, 1'b0},
        {32'hFFFF_0000, 32'h0000_8000, 1'b1, 1'b0},
        {32'h0000_0000, 32'h0000_0000, 1'b0, 1'b0}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic s, input logic [31:0] d);
        @(negedge clk); sel = s; wdata = d; wr_en = 1'b1;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic do_read(input logic s);
        @(negedge clk); sel = s; rd_en = 1'b1;
        @(negedge clk); rd_en = 1'b0;
    endtask

    task automatic pulse(input logic [31:0] e);
        @(negedge clk); evt = e;
        @(negedge clk); evt = '0;
    endtask

    initial begin
        #(20 * 100000);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 irq in reset", {31'b0, irq}, 32'h0);
        chk("R1 fatal in reset", {31'b0, fatal}, 32'h0);
        rst_n = 1'b1;
        do_read(1'b1);
        chk("R1 mask reset value", rdata, 32'hFF7F_FFFF);
        do_read(1'b0);
        chk("R1 status reset value", rdata, 32'h0);

        // Table walk: mask, event, output check, status read, post-read check.
        foreach (VEC[i]) begin
            do_write(1'b1, VEC[i][65:34]);
            pulse(VEC[i][33:2]);
            chk("R7 irq after event", {31'b0, irq}, {31'b0, VEC[i][1]});
            chk("R9 fatal after event", {31'b0, fatal}, {31'b0, VEC[i][0]});
            do_read(1'b0);
            chk("R3 R8 status read value", rdata, VEC[i][33:2] & 32'hFF7F_FFFF);
            chk("R4 irq after read", {31'b0, irq}, 32'h0);
            chk("R4 fatal after read", {31'b0, fatal}, 32'h0);
            do_read(1'b1);
            chk("R6 mask readback", rdata, VEC[i][65:34]);
        end

        // R2: stickiness over idle cycles.
        do_write(1'b1, 32'h0000_0000);
        pulse(32'h0000_0024);
        repeat (5) @(negedge clk);
        chk("R2 sticky irq", {31'b0, irq}, 32'h1);
        // R10: write to status does nothing.
        do_write(1'b0, 32'hFFFF_FFFF);
        do_read(1'b0);
        chk("R10 R2 status unchanged by write", rdata, 32'h0000_0024);

        // R5: event coincides with the clearing read.
        pulse(32'h0000_0004);
        @(negedge clk); sel = 1'b0; rd_en = 1'b1; evt = 32'h0000_0020;
        @(negedge clk); rd_en = 1'b0; evt = '0;
        chk("R5 read excludes coincident event", rdata, 32'h0000_0004);
        chk("R5 irq from coincident event", {31'b0, irq}, 32'h1);
        do_read(1'b0);
        chk("R5 coincident event kept", rdata, 32'h0000_0020);

        // R8: level bit with mask all ones.
        do_write(1'b1, 32'hFFFF_FFFF);
        @(negedge clk); lvl = 1'b1;
        @(negedge clk);
        chk("R8 level drives irq through mask", {31'b0, irq}, 32'h1);
        do_read(1'b0);
        chk("R8 read shows level bit", rdata, 32'h0080_0000);
        chk("R8 level not cleared by read", {31'b0, irq}, 32'h1);
        do_read(1'b0);
        chk("R8 level still shown", rdata, 32'h0080_0000);
        @(negedge clk); lvl = 1'b0;
        @(negedge clk);
        chk("R8 irq follows level low", {31'b0, irq}, 32'h0);

        // R9: fatal ignores mask, R6: mask read leaves status intact.
        pulse(32'h0010_0000);
        chk("R9 fatal with mask set", {31'b0, fatal}, 32'h1);
        chk("R7 masked fatal no irq", {31'b0, irq}, 32'h0);
        do_read(1'b1);
        chk("R6 mask read keeps fatal", {31'b0, fatal}, 32'h1);

        // R1: reset mid-run restores defaults.
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        chk("R1 fatal cleared by reset", {31'b0, fatal}, 32'h0);
        do_read(1'b1);
        chk("R1 mask restored", rdata, 32'hFF7F_FFFF);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule